// File: doc/BRIEF.md
# Rate-Configurable Viterbi Symbol Input Buffer

This block sits on the write side of a convolutional encode/decode and equalize datapath. A host bus or a DMA engine writes 16-bit words into it. The block groups those words into complete symbols and hands each symbol to a downstream consumer over a valid/ready handshake. How many writes make one symbol depends on the operating mode and, in decode mode, on the code rate.

`mode_i` selects the mode. Code 0 is encode, code 1 is decode, and codes 2 and 3 are both equalize. In decode mode, each write carries one 8-bit soft symbol-bit in its upper byte. The symbol-bits of a symbol arrive in generator-polynomial order, so lane i of the output holds the bit for generator i. In encode mode, each write is a hard value that the block reduces to one bit. In equalize mode, each write is one complete 16-bit sample.

Decode and equalize modes keep two symbol slots, so one symbol can fill while the other waits for the consumer. Encode mode keeps one slot. The `req_o` output tells the writer when another symbol can be accepted.

Top module: `vsib_sym_inbuf`

## Requirements
- R1: After reset, `req_o` is 1, `sym_valid_o` is 0 and `ovf_o` is 0.
- R2: In decode mode (`mode_i`=1), `rate_i` codes 0, 1, 2 and 3 need 2, 3, 4 and 6 writes per symbol. The symbol becomes valid in the cycle after its last write. Lane i, `sym_lanes_o[8i+7:8i]`, holds bits [15:8] of the i-th write of the symbol, counting from 0. Lanes beyond the rate's count read 0.
- R3: In decode mode, bits [7:0] of each written word have no effect on any output.
- R4: In encode mode (`mode_i`=0), one write forms a symbol. `sym_bit_o` equals bit 15 of the word, so 0x8000 gives 1 and 0x7FFF gives 0. `sym_word_o` carries the raw word.
- R5: In equalize mode (`mode_i`=2 or 3), one write forms a symbol, and `sym_word_o` carries that word.
- R6: The block holds at most two symbols in decode and equalize modes and at most one in encode mode. `req_o` is 1 exactly when fewer symbols are held than that limit. `req_o` falls in the cycle after the write that fills the last slot and rises in the cycle after a pop.
- R7: A write made while `req_o` is 0 is dropped, even if a pop happens in the same cycle. Such a write sets `ovf_o` in the next cycle. `ovf_o` stays set until `ovf_clr_i` is pulsed. If a dropped write and a clear arrive in the same cycle, the flag is set.
- R8: Symbols leave in the order they were completed. While `sym_valid_o` is 1 and `sym_ready_i` is 0, the symbol outputs hold steady.
- R9: Changing `mode_i` or `rate_i` discards the partial symbol and every held symbol, and restarts lane filling at lane 0, in the following cycle. A write in the same cycle as the change is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 encode, 1 decode, 2/3 equalize |
| rate_i | input | 2 | Decode code rate: 0=1/2, 1=1/3, 2=1/4, 3=1/6 |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data word |
| req_o | output | 1 | Room for another symbol |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky dropped-write flag |
| sym_valid_o | output | 1 | Head symbol available |
| sym_ready_i | input | 1 | Consumer takes the head symbol |
| sym_lanes_o | output | 48 | Decode lanes, lane i at bits [8i+7:8i] |
| sym_word_o | output | 16 | Raw word in encode and equalize modes |
| sym_bit_o | output | 1 | Hard bit in encode mode |

## Verification
The assertions assume that `mode_i` and `rate_i` are held steady except when a deliberate reconfiguration is made, and that `ovf_clr_i` is asserted only on purpose. The hold-steady property also assumes that a consumer which deasserts ready lets the same head symbol stand. The stimulus changes configuration only while no write is pending, and it raises ready only in single-cycle pop pulses. Every symbol is therefore observed while stalled before it is taken. Overflow is provoked only by writes made on purpose while `req_o` is low.

// File: rtl/vsib_pkg.sv
package vsib_pkg;

  localparam logic [1:0] MODE_ENC = 2'd0;
  localparam logic [1:0] MODE_DEC = 2'd1;

  // symbol-bits per decode symbol for each rate code
  function automatic logic [2:0] lanes_per_sym(input logic [1:0] rate);
    case (rate)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  // slots usable in a mode: encode is single-buffered
  function automatic logic [1:0] slot_cap(input logic [1:0] mode);
    return (mode == MODE_ENC) ? 2'd1 : 2'd2;
  endfunction

  // hard-value word to bit: the sign bit separates 0x8000 from 0x7FFF
  function automatic logic hard_bit(input logic [15:0] word);
    return word[15];
  endfunction

endpackage

// File: rtl/vsib_lane_asm.sv
module vsib_lane_asm #(
  parameter int LANE_W    = 8,
  parameter int MAX_LANES = 6,
  localparam int SYM_W    = LANE_W * MAX_LANES,
  localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [CNT_W-1:0]  nlanes_i,
  output logic              commit_o,
  output logic [SYM_W-1:0]  lanes_o,
  output logic [CNT_W-1:0]  idx_o
);

  logic [SYM_W-1:0] part_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_w;

  always_comb begin
    lanes_o = part_q;
    lanes_o[idx_q*LANE_W +: LANE_W] = lane_i;
  end

  assign last_w   = (idx_q == CNT_W'(nlanes_i - 1'b1));
  assign commit_o = wr_i && last_w;
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      idx_q  <= '0;
    end else if (flush_i) begin
      part_q <= '0;
      idx_q  <= '0;
    end else if (wr_i) begin
      if (last_w) begin
        part_q <= '0;
        idx_q  <= '0;
      end else begin
        part_q <= lanes_o;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vsib_slot_q.sv
module vsib_slot_q #(
  parameter int W     = 65,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic             valid_o,
  output logic [W-1:0]     dout_o
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q >= cap_i);
  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        mem_q[g] <= '0;
      else if (push_i && !flush_i && wr_q == PTR_W'(g))  mem_q[g] <= din_i;
    end
  end

endmodule

// File: rtl/vsib_sym_inbuf.sv
module vsib_sym_inbuf
  import vsib_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int MAX_LANES = 6,
  parameter int SLOTS     = 2,
  localparam int SYM_W    = LANE_W * MAX_LANES,
  localparam int PAY_W    = SYM_W + DATA_W + 1,
  localparam int CNT_W    = $clog2(MAX_LANES + 1),
  localparam int SCNT_W   = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        rate_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              req_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o,
  output logic              sym_valid_o,
  input  logic              sym_ready_i,
  output logic [SYM_W-1:0]  sym_lanes_o,
  output logic [DATA_W-1:0] sym_word_o,
  output logic              sym_bit_o
);

  logic [1:0] mode_q, rate_q;
  logic       flush_w, full_w, acc_w, drop_w, pop_w, push_w, is_dec_w;
  logic       asm_commit_w;
  logic [SYM_W-1:0] asm_lanes_w;
  logic [CNT_W-1:0] lane_idx_w;
  logic [PAY_W-1:0] din_w, dout_w;
  logic             ovf_q;

  assign flush_w  = (mode_i != mode_q) || (rate_i != rate_q);
  assign is_dec_w = (mode_i == MODE_DEC);
  assign acc_w    = wr_en_i && !full_w && !flush_w;
  assign drop_w   = wr_en_i &&  full_w && !flush_w;
  assign pop_w    = sym_valid_o && sym_ready_i && !flush_w;
  assign push_w   = is_dec_w ? asm_commit_w : acc_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ENC;
      rate_q <= 2'd0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      rate_q <= rate_i;
      if (drop_w)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  vsib_lane_asm #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (flush_w),
    .wr_i     (acc_w && is_dec_w),
    .lane_i   (wr_data_i[DATA_W-1 -: LANE_W]),
    .nlanes_i (CNT_W'(lanes_per_sym(rate_i))),
    .commit_o (asm_commit_w),
    .lanes_o  (asm_lanes_w),
    .idx_o    (lane_idx_w)
  );

  always_comb begin
    if (is_dec_w)
      din_w = {asm_lanes_w, {DATA_W{1'b0}}, 1'b0};
    else
      din_w = {{SYM_W{1'b0}}, wr_data_i,
               (mode_i == MODE_ENC) ? hard_bit(wr_data_i) : 1'b0};
  end

  vsib_slot_q #(.W(PAY_W), .DEPTH(SLOTS)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_w),
    .cap_i   (SCNT_W'(slot_cap(mode_i))),
    .push_i  (push_w),
    .din_i   (din_w),
    .pop_i   (pop_w),
    .full_o  (full_w),
    .valid_o (sym_valid_o),
    .dout_o  (dout_w)
  );

  assign req_o       = !full_w;
  assign ovf_o       = ovf_q;
  assign sym_lanes_o = dout_w[PAY_W-1 -: SYM_W];
  assign sym_word_o  = dout_w[DATA_W:1];
  assign sym_bit_o   = dout_w[0];

endmodule

// File: rtl/vsib_chk.sv
module vsib_chk
  import vsib_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_i,
  input logic [1:0]  rate_i,
  input logic        req_o,
  input logic        ovf_clr_i,
  input logic        ovf_o,
  input logic        sym_valid_o,
  input logic        sym_ready_i,
  input logic [47:0] sym_lanes_o,
  input logic [15:0] sym_word_o,
  input logic        flush_w,
  input logic        drop_w,
  input logic [2:0]  lane_idx_w
);

  AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid_o |-> req_o);  // R6

  AST_ENC_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ENC) && !flush_w && sym_valid_o |-> !req_o);  // R6

  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> ovf_o);  // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);  // R7

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o && !sym_ready_i && !flush_w
      |=> sym_valid_o && $stable(sym_lanes_o) && $stable(sym_word_o));  // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> !sym_valid_o && req_o && lane_idx_w == 3'd0);  // R9

  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_w |-> lane_idx_w < lanes_per_sym(rate_i));  // R2

endmodule

bind vsib_sym_inbuf vsib_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .rate_i      (rate_i),
  .req_o       (req_o),
  .ovf_clr_i   (ovf_clr_i),
  .ovf_o       (ovf_o),
  .sym_valid_o (sym_valid_o),
  .sym_ready_i (sym_ready_i),
  .sym_lanes_o (sym_lanes_o),
  .sym_word_o  (sym_word_o),
  .flush_w     (flush_w),
  .drop_w      (drop_w),
  .lane_idx_w  (lane_idx_w)
);

// File: tb/vsib_sym_inbuf_tb.sv
`timescale 1ns/1ps
module vsib_sym_inbuf_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0, rate_i = 2'd0;
  logic        wr_en_i = 1'b0, ovf_clr_i = 1'b0, sym_ready_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        req_o, ovf_o, sym_valid_o, sym_bit_o;
  logic [47:0] sym_lanes_o;
  logic [15:0] sym_word_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vsib_sym_inbuf u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rate_i(rate_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .req_o(req_o),
    .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .sym_valid_o(sym_valid_o),
    .sym_ready_i(sym_ready_i), .sym_lanes_o(sym_lanes_o),
    .sym_word_o(sym_word_o), .sym_bit_o(sym_bit_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk); #1 wr_en_i = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); sym_ready_i = 1'b1;
    @(posedge clk); #1 sym_ready_i = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] r);
    @(negedge clk); mode_i = m; rate_i = r;
    @(posedge clk); #1;
  endtask

  task automatic clr_ovf();
    @(negedge clk); ovf_clr_i = 1'b1;
    @(posedge clk); #1 ovf_clr_i = 1'b0;
  endtask

  function automatic int nl(input int r);
    return (r == 3) ? 6 : r + 2;
  endfunction

  function automatic logic [7:0] lane_val(input int r, input int s, input int i);
    return 8'(r * 64 + s * 32 + i * 5 + 3);
  endfunction

  function automatic logic [47:0] exp_lanes(input int r, input int s);
    logic [47:0] e = '0;
    for (int i = 0; i < nl(r); i++) e[8*i +: 8] = lane_val(r, s, i);
    return e;
  endfunction

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R1 req at reset", 64'(req_o), 64'd1);
    chk("R1 valid at reset", 64'(sym_valid_o), 64'd0);
    chk("R1 ovf at reset", 64'(ovf_o), 64'd0);
    #9 rst_n = 1'b1;

    // decode sweep over every rate: two symbols, one overflow, drain
    for (int r = 0; r < 4; r++) begin
      set_cfg(2'd1, 2'(r));
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < nl(r); i++) begin
          // low byte is junk that must not reach the lanes (R3)
          wr({lane_val(r, s, i), 8'(8'hC3 ^ (s * 16 + i * 7 + r))});
          if (i < nl(r) - 1)
            chk($sformatf("R2 not valid mid-symbol r%0d s%0d", r, s),
                64'(sym_valid_o), 64'(s));
        end
        chk($sformatf("R2 valid after last write r%0d", r), 64'(sym_valid_o), 64'd1);
        chk($sformatf("R6 req after symbol %0d r%0d", s, r), 64'(req_o), 64'(s == 0));
        chk($sformatf("R2 R3 head lanes r%0d", r), 64'(sym_lanes_o), 64'(exp_lanes(r, 0)));
      end
      wr(16'hFFFF);
      chk($sformatf("R7 ovf after drop r%0d", r), 64'(ovf_o), 64'd1);
      pop();
      chk($sformatf("R8 second symbol in order r%0d", r), 64'(sym_lanes_o), 64'(exp_lanes(r, 1)));
      chk($sformatf("R6 req after pop r%0d", r), 64'(req_o), 64'd1);
      pop();
      chk($sformatf("R7 dropped write left nothing r%0d", r), 64'(sym_valid_o), 64'd0);
      chk($sformatf("R7 ovf sticky r%0d", r), 64'(ovf_o), 64'd1);
      clr_ovf();
      chk($sformatf("R7 ovf cleared r%0d", r), 64'(ovf_o), 64'd0);
    end

    // encode: single slot, hard bit
    set_cfg(2'd0, 2'd0);
    wr(16'h8000);
    chk("R4 valid after one write", 64'(sym_valid_o), 64'd1);
    chk("R4 bit for 0x8000", 64'(sym_bit_o), 64'd1);
    chk("R4 raw word", 64'(sym_word_o), 64'h8000);
    chk("R6 encode holds one", 64'(req_o), 64'd0);
    wr(16'h7FFF);
    chk("R7 encode overflow", 64'(ovf_o), 64'd1);
    chk("R7 dropped write ignored", 64'(sym_bit_o), 64'd1);
    pop();
    chk("R6 req back in encode", 64'(req_o), 64'd1);
    wr(16'h7FFF);
    chk("R4 bit for 0x7FFF", 64'(sym_bit_o), 64'd0);
    pop();
    clr_ovf();

    // equalize: two slots, raw words, stall holds output
    set_cfg(2'd2, 2'd0);
    wr(16'h1234);
    chk("R5 word stored", 64'(sym_word_o), 64'h1234);
    chk("R6 req with one held", 64'(req_o), 64'd1);
    wr(16'hBEEF);
    chk("R6 req with two held", 64'(req_o), 64'd0);
    repeat (3) @(posedge clk);
    #1 chk("R8 stalled head stable", 64'(sym_word_o), 64'h1234);
    pop();
    chk("R8 order in equalize", 64'(sym_word_o), 64'hBEEF);
    pop();
    chk("R5 drained", 64'(sym_valid_o), 64'd0);

    // equalize alias code 3
    set_cfg(2'd3, 2'd0);
    wr(16'h0A5A);
    chk("R5 mode 3 word", 64'(sym_word_o), 64'h0A5A);
    pop();

    // reconfiguration flush
    set_cfg(2'd1, 2'd1);
    wr(16'h0100); wr(16'h0200); wr(16'h0300);
    wr(16'h1100);
    set_cfg(2'd1, 2'd0);
    chk("R9 slots flushed", 64'(sym_valid_o), 64'd0);
    chk("R9 req after flush", 64'(req_o), 64'd1);
    wr(16'h2200);
    chk("R9 partial discarded", 64'(sym_valid_o), 64'd0);
    wr(16'h3300);
    chk("R9 lanes restart at 0", 64'(sym_lanes_o), 64'h3322);
    pop();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule